// File: doc/BRIEF.md
# Per-Sector Write Protection Controller

This block decides, sector by sector, whether a program or erase request may go ahead. Protection is layered. Each sector has a persistent bit that behaves like a flash cell: 1 is erased (unprotected), 0 is programmed (protected). Each sector also has a volatile dynamic bit that can block a sector whose persistent bit is still erased. A global lock bit freezes every persistent bit. A one-time mode register selects between persistent-lock mode and password mode. In password mode a 64-bit password is needed to reopen the global lock.

A host changes the protection state with a small command interface. It first enters one of four command sets, then issues set, clear, lock, unlock or read operations inside that set, then exits back to normal operation. An access request names a sector, and one cycle later the block answers with a registered allow flag.

There are two resets. The power-on reset `por` models power being applied and clears everything. The hardware reset `rst` clears only the volatile state; the persistent bits, the mode register and the password survive it.

Top module: `sector_guard`

## Requirements
- R1: After `por` every sector is allowed. The mode register reads 0, which is persistent-lock mode with neither mode bit set, and the global lock reads 1 (open).
- R2: Sampling `req_valid` at a clock edge sets `allow_valid` for the next cycle. In that cycle `allow` is 1 exactly when the sector's persistent bit is 1 and its dynamic bit is 0.
- R3: In the dynamic set, SET protects one sector and CLEAR unprotects one sector, leaving the others unchanged. A sector whose persistent bit is 0 stays blocked whatever its dynamic bit is.
- R4: In the persistent set, SET programs the addressed sector's persistent bit to 0 only while the global lock is 1. While the lock is 0, no persistent bit changes.
- R5: In the persistent set, CLEAR erases every persistent bit to 1 at once, whatever `cmd_sector` holds, but only while the global lock is 1.
- R6: In the persistent set, LOCK drives the global lock to 0. In persistent-lock mode only a reset reopens it.
- R7: `rst` clears every dynamic bit and leaves the command-set state in normal operation. It sets the lock to 1 when mode bit 1 is 0, and to 0 when mode bit 1 is 1. The persistent bits, the mode register and the password keep their values.
- R8: Operation codes are: 0 no-op, 1 ENTER, 2 EXIT, 3 SET, 4 CLEAR, 5 LOCK, 6 UNLOCK, 7 READ. ENTER is accepted only in normal operation, and `cmd_data[1:0]` picks the set: 0 mode register, 1 persistent, 2 dynamic, 3 password. EXIT returns to normal operation. In normal operation every operation except ENTER is ignored.
- R9: In the mode-register set, SET is accepted only while both mode bits are 0 and only when `cmd_data[1:0]` is 01 (persistent-lock, bit 0) or 10 (password mode, bit 1). Once a bit is set, the mode register never changes again until `por`.
- R10: In the password set, SET stores `cmd_data` and READ returns the password, but only while mode bit 1 is 0. Once mode bit 1 is 1, READ returns all ones and SET is ignored.
- R11: In the password set with mode bit 1 at 1, UNLOCK with `cmd_data` equal to the stored password sets the lock to 1. A value that does not match has no effect.
- R12: READ in any set raises `rd_valid` for the next cycle. `rd_data` then holds:
  - in the persistent set, the sector's persistent bit at bit 0;
  - in the dynamic set, its dynamic bit at bit 0;
  - in the mode-register set, {lock, mode[1], mode[0]} at bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high, clears all state |
| rst | input | 1 | Hardware reset, synchronous, active high, clears volatile state |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Operation code |
| cmd_sector | input | SECT_W | Sector addressed by the command |
| cmd_data | input | PW_W | Set selector, mode value or password |
| req_valid | input | 1 | Access request strobe |
| req_sector | input | SECT_W | Sector named by the access request |
| allow_valid | output | 1 | Answer to a request is present |
| allow | output | 1 | Program or erase is permitted |
| rd_valid | output | 1 | Read data is present |
| rd_data | output | PW_W | Read result |

## Verification
Every command takes effect at the clock edge that samples it. An access request made in the next cycle therefore already sees the new protection state, and its answer on `allow` is due one cycle after the request. READ data is likewise due one cycle after the READ is sampled. The bench drives inputs on falling edges and checks each result on the falling edge that follows the sampling edge. It compares against a bench model that it updates right after driving each command. A short directed sequence covers the lock, mode and password corners. Seeded random command streams with occasional hardware resets then cover the remaining state combinations.

// File: rtl/sg_pkg.sv
package sg_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ENTER  = 3'd1,
    OP_EXIT   = 3'd2,
    OP_SET    = 3'd3,
    OP_CLEAR  = 3'd4,
    OP_LOCK   = 3'd5,
    OP_UNLOCK = 3'd6,
    OP_READ   = 3'd7
  } sg_op_e;

  typedef enum logic [2:0] {
    CS_NONE    = 3'd0,
    CS_MODEREG = 3'd1,
    CS_PERSIST = 3'd2,
    CS_DYNAMIC = 3'd3,
    CS_PASS    = 3'd4
  } sg_cset_e;

  typedef struct packed {
    logic per_prog;
    logic per_erase_all;
    logic per_freeze;
    logic dyn_set;
    logic dyn_clr;
    logic mode_prog;
    logic pw_prog;
    logic pw_unlock;
    logic rd_per;
    logic rd_dyn;
    logic rd_mode;
    logic rd_pw;
  } sg_strobe_t;

endpackage

// File: rtl/sg_cmd_decode.sv
module sg_cmd_decode
  import sg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [1:0] cmd_sel,
  output sg_strobe_t strb,
  output sg_cset_e   cset
);

  sg_op_e   op;
  sg_cset_e sel_cset;

  assign op = sg_op_e'(cmd_op);

  always_comb begin
    case (cmd_sel)
      2'd0:    sel_cset = CS_MODEREG;
      2'd1:    sel_cset = CS_PERSIST;
      2'd2:    sel_cset = CS_DYNAMIC;
      default: sel_cset = CS_PASS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cset <= CS_NONE;
    end else if (cmd_valid) begin
      if (op == OP_ENTER && cset == CS_NONE) cset <= sel_cset;
      else if (op == OP_EXIT)                cset <= CS_NONE;
    end
  end

  always_comb begin
    strb = '0;
    if (cmd_valid) begin
      case (op)
        OP_SET: begin
          strb.mode_prog = (cset == CS_MODEREG);
          strb.per_prog  = (cset == CS_PERSIST);
          strb.dyn_set   = (cset == CS_DYNAMIC);
          strb.pw_prog   = (cset == CS_PASS);
        end
        OP_CLEAR: begin
          strb.per_erase_all = (cset == CS_PERSIST);
          strb.dyn_clr       = (cset == CS_DYNAMIC);
        end
        OP_LOCK:   strb.per_freeze = (cset == CS_PERSIST);
        OP_UNLOCK: strb.pw_unlock  = (cset == CS_PASS);
        OP_READ: begin
          strb.rd_mode = (cset == CS_MODEREG);
          strb.rd_per  = (cset == CS_PERSIST);
          strb.rd_dyn  = (cset == CS_DYNAMIC);
          strb.rd_pw   = (cset == CS_PASS);
        end
        default: strb = '0;
      endcase
    end
  end

  AST_ENTER_NESTED_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cset != CS_NONE && cmd_valid && op == OP_ENTER) |=> (cset == $past(cset))); // R8

  AST_EXIT_TO_READ: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_EXIT) |=> (cset == CS_NONE)); // R8

endmodule

// File: rtl/sg_bit_array.sv
module sg_bit_array #(
  parameter int   NUM_BITS = 64,
  parameter int   IDX_W    = $clog2(NUM_BITS),
  parameter logic RST_VAL  = 1'b0,
  parameter logic FILL_VAL = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                wr_val,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic                fill_en,
  output logic [NUM_BITS-1:0] bits
);

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)                                  bits[i] <= RST_VAL;
      else if (fill_en)                         bits[i] <= FILL_VAL;
      else if (wr_en && wr_idx == IDX_W'(i))    bits[i] <= wr_val;
    end
  end

  AST_FILL_ALL: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> (bits == {NUM_BITS{FILL_VAL}})); // R5

endmodule

// File: rtl/sg_mode_regs.sv
module sg_mode_regs #(
  parameter int PW_W = 64
) (
  input  logic            clk,
  input  logic            por,
  input  logic            rst,
  input  logic            mode_prog,
  input  logic            pw_prog,
  input  logic            pw_unlock,
  input  logic            freeze,
  input  logic [PW_W-1:0] data,
  output logic [1:0]      mode,
  output logic            lock,
  output logic [PW_W-1:0] pw
);

  logic mode_ok;
  assign mode_ok = (mode == 2'b00) && (data[1:0] == 2'b01 || data[1:0] == 2'b10);

  always_ff @(posedge clk) begin
    if (por) begin
      mode <= 2'b00;
      pw   <= '1;
    end else begin
      if (mode_prog && mode_ok) mode <= data[1:0];
      if (pw_prog && !mode[1])  pw   <= data;
    end
  end

  always_ff @(posedge clk) begin
    if (por)                                    lock <= 1'b1;
    else if (rst)                               lock <= ~mode[1];
    else if (pw_unlock && mode[1] && data == pw) lock <= 1'b1;
    else if (freeze)                            lock <= 1'b0;
  end

  AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (por)
    $onehot0(mode)); // R9

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (por)
    (mode != 2'b00) |=> $stable(mode)); // R9

  AST_PW_FROZEN: assert property (@(posedge clk) disable iff (por)
    mode[1] |=> $stable(pw)); // R10

  AST_LOCK_REOPEN: assert property (@(posedge clk) disable iff (por || rst)
    ($rose(lock) && !$past(rst)) |-> $past(mode[1])); // R6

endmodule

// File: rtl/sg_access.sv
module sg_access #(
  parameter int NUM_SECTORS = 64,
  parameter int SECT_W      = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [SECT_W-1:0]      req_sector,
  input  logic [NUM_SECTORS-1:0] per_bits,
  input  logic [NUM_SECTORS-1:0] dyn_bits,
  output logic                   allow_valid,
  output logic                   allow
);

  logic per_sel, dyn_sel;
  assign per_sel = per_bits[req_sector];
  assign dyn_sel = dyn_bits[req_sector];

  always_ff @(posedge clk) begin
    if (rst) begin
      allow_valid <= 1'b0;
      allow       <= 1'b0;
    end else begin
      allow_valid <= req_valid;
      allow       <= req_valid && per_sel && !dyn_sel;
    end
  end

  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> allow_valid); // R2

  AST_ALLOW_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    allow |-> allow_valid); // R2

endmodule

// File: rtl/sg_readback.sv
module sg_readback
  import sg_pkg::*;
#(
  parameter int NUM_SECTORS = 64,
  parameter int SECT_W      = $clog2(NUM_SECTORS),
  parameter int PW_W        = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  sg_strobe_t             strb,
  input  logic [SECT_W-1:0]      sector,
  input  logic [NUM_SECTORS-1:0] per_bits,
  input  logic [NUM_SECTORS-1:0] dyn_bits,
  input  logic [1:0]             mode,
  input  logic                   lock,
  input  logic [PW_W-1:0]        pw,
  output logic                   rd_valid,
  output logic [PW_W-1:0]        rd_data
);

  localparam int PAD_W = PW_W - 3;

  logic            any_rd;
  logic [PW_W-1:0] rd_next;

  assign any_rd = strb.rd_per | strb.rd_dyn | strb.rd_mode | strb.rd_pw;

  always_comb begin
    rd_next = '0;
    if (strb.rd_per)       rd_next = {{(PW_W-1){1'b0}}, per_bits[sector]};
    else if (strb.rd_dyn)  rd_next = {{(PW_W-1){1'b0}}, dyn_bits[sector]};
    else if (strb.rd_mode) rd_next = {{PAD_W{1'b0}}, lock, mode};
    else if (strb.rd_pw)   rd_next = mode[1] ? '1 : pw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= any_rd;
      if (any_rd) rd_data <= rd_next;
    end
  end

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    any_rd |=> rd_valid); // R12

endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sg_pkg::*;
#(
  parameter int NUM_SECTORS = 64,
  parameter int SECT_W      = $clog2(NUM_SECTORS),
  parameter int PW_W        = 64
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [SECT_W-1:0] cmd_sector,
  input  logic [PW_W-1:0]   cmd_data,
  input  logic              req_valid,
  input  logic [SECT_W-1:0] req_sector,
  output logic              allow_valid,
  output logic              allow,
  output logic              rd_valid,
  output logic [PW_W-1:0]   rd_data
);

  logic                   rst_any;
  sg_strobe_t             strb;
  sg_cset_e               cset;
  logic [NUM_SECTORS-1:0] per_bits;
  logic [NUM_SECTORS-1:0] dyn_bits;
  logic [1:0]             mode;
  logic                   lock;
  logic [PW_W-1:0]        pw;

  assign rst_any = por | rst;

  sg_cmd_decode u_decode (
    .clk       (clk),
    .rst       (rst_any),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_sel   (cmd_data[1:0]),
    .strb      (strb),
    .cset      (cset)
  );

  sg_bit_array #(
    .NUM_BITS (NUM_SECTORS),
    .IDX_W    (SECT_W),
    .RST_VAL  (1'b1),
    .FILL_VAL (1'b1)
  ) u_persist (
    .clk     (clk),
    .rst     (por),
    .wr_en   (strb.per_prog & lock),
    .wr_val  (1'b0),
    .wr_idx  (cmd_sector),
    .fill_en (strb.per_erase_all & lock),
    .bits    (per_bits)
  );

  sg_bit_array #(
    .NUM_BITS (NUM_SECTORS),
    .IDX_W    (SECT_W),
    .RST_VAL  (1'b0),
    .FILL_VAL (1'b0)
  ) u_dynamic (
    .clk     (clk),
    .rst     (rst_any),
    .wr_en   (strb.dyn_set | strb.dyn_clr),
    .wr_val  (strb.dyn_set),
    .wr_idx  (cmd_sector),
    .fill_en (1'b0),
    .bits    (dyn_bits)
  );

  sg_mode_regs #(.PW_W(PW_W)) u_mode (
    .clk       (clk),
    .por       (por),
    .rst       (rst),
    .mode_prog (strb.mode_prog),
    .pw_prog   (strb.pw_prog),
    .pw_unlock (strb.pw_unlock),
    .freeze    (strb.per_freeze),
    .data      (cmd_data),
    .mode      (mode),
    .lock      (lock),
    .pw        (pw)
  );

  sg_access #(.NUM_SECTORS(NUM_SECTORS), .SECT_W(SECT_W)) u_access (
    .clk         (clk),
    .rst         (rst_any),
    .req_valid   (req_valid),
    .req_sector  (req_sector),
    .per_bits    (per_bits),
    .dyn_bits    (dyn_bits),
    .allow_valid (allow_valid),
    .allow       (allow)
  );

  sg_readback #(.NUM_SECTORS(NUM_SECTORS), .SECT_W(SECT_W), .PW_W(PW_W)) u_read (
    .clk      (clk),
    .rst      (rst_any),
    .strb     (strb),
    .sector   (cmd_sector),
    .per_bits (per_bits),
    .dyn_bits (dyn_bits),
    .mode     (mode),
    .lock     (lock),
    .pw       (pw),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  AST_PERSIST_FROZEN: assert property (@(posedge clk) disable iff (por)
    !lock |=> $stable(per_bits)); // R4

  AST_DYN_CLEARED_BY_RST: assert property (@(posedge clk) disable iff (por)
    rst |=> (dyn_bits == '0 && cset == CS_NONE)); // R7

  AST_PERSIST_KEEP_RST: assert property (@(posedge clk) disable iff (por)
    rst |=> $stable(per_bits)); // R7

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst_any)
    (cset == CS_NONE) |-> (strb == '0)); // R8

endmodule

// File: tb/test_sector_guard.sv
module test_sector_guard;
  import sg_pkg::*;

  localparam int NS   = 16;
  localparam int SW   = 4;
  localparam int PW_W = 64;

  logic            clk = 1'b0;
  logic            por = 1'b1;
  logic            rst = 1'b0;
  logic            cmd_valid = 1'b0;
  logic [2:0]      cmd_op = 3'd0;
  logic [SW-1:0]   cmd_sector = '0;
  logic [PW_W-1:0] cmd_data = '0;
  logic            req_valid = 1'b0;
  logic [SW-1:0]   req_sector = '0;
  logic            allow_valid, allow, rd_valid;
  logic [PW_W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // bench model
  logic [NS-1:0]   m_per;
  logic [NS-1:0]   m_dyn;
  logic            m_lock;
  logic [1:0]      m_mode;
  logic [PW_W-1:0] m_pw;
  int              m_ctx;

  sector_guard #(.NUM_SECTORS(NS), .SECT_W(SW), .PW_W(PW_W)) i_sector_guard (
    .clk, .por, .rst, .cmd_valid, .cmd_op, .cmd_sector, .cmd_data,
    .req_valid, .req_sector, .allow_valid, .allow, .rd_valid, .rd_data
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [PW_W-1:0] act, input logic [PW_W-1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [PW_W-1:0] exp_read(input int s);
    case (m_ctx)
      1:       return {{(PW_W-3){1'b0}}, m_lock, m_mode};
      2:       return {{(PW_W-1){1'b0}}, m_per[s]};
      3:       return {{(PW_W-1){1'b0}}, m_dyn[s]};
      default: return m_mode[1] ? '1 : m_pw;
    endcase
  endfunction

  function automatic void model_power_on();
    m_per = '1; m_dyn = '0; m_lock = 1'b1; m_mode = 2'b00; m_pw = '1; m_ctx = 0;
  endfunction

  function automatic void model_apply(input logic [2:0] op, input int s, input logic [PW_W-1:0] d);
    case (op)
      3'd1: if (m_ctx == 0) m_ctx = int'(d[1:0]) + 1;
      3'd2: m_ctx = 0;
      3'd3: begin
        if (m_ctx == 1 && m_mode == 2'b00 && (d[1:0] == 2'b01 || d[1:0] == 2'b10)) m_mode = d[1:0];
        if (m_ctx == 2 && m_lock) m_per[s] = 1'b0;
        if (m_ctx == 3) m_dyn[s] = 1'b1;
        if (m_ctx == 4 && !m_mode[1]) m_pw = d;
      end
      3'd4: begin
        if (m_ctx == 2 && m_lock) m_per = '1;
        if (m_ctx == 3) m_dyn[s] = 1'b0;
      end
      3'd5: if (m_ctx == 2) m_lock = 1'b0;
      3'd6: if (m_ctx == 4 && m_mode[1] && d == m_pw) m_lock = 1'b1;
      default: ;
    endcase
  endfunction

  task automatic cmd(input logic [2:0] op, input int s, input logic [PW_W-1:0] d, input string tag);
    logic            is_rd;
    logic [PW_W-1:0] e;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sector = SW'(s); cmd_data = d;
    is_rd = (op == 3'd7) && (m_ctx != 0);
    e = exp_read(s);
    model_apply(op, s, d);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    if (is_rd) begin
      chk({tag, " rd_valid"}, {63'b0, rd_valid}, 64'd1);
      chk(tag, rd_data, e);
    end
  endtask

  task automatic ask(input int s, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_sector = SW'(s);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " allow_valid"}, {63'b0, allow_valid}, 64'd1);
    chk(tag, {63'b0, allow}, {63'b0, (m_per[s] & ~m_dyn[s])});
  endtask

  task automatic hw_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_dyn = '0; m_lock = ~m_mode[1]; m_ctx = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_power_on();
    repeat (3) @(negedge clk);
    por = 1'b0;
    @(negedge clk);

    // R1: power-on state
    chk("R1 allow_valid idle", {63'b0, allow_valid}, 64'd0);
    for (int s = 0; s < NS; s++) ask(s, "R1 sector open");
    cmd(3'd1, 0, 64'd0, "R8 enter mode set");
    cmd(3'd7, 0, 64'd0, "R1 mode/lock read");
    cmd(3'd2, 0, 64'd0, "R8 exit");

    // R8: ignored outside a set
    cmd(3'd3, 7, 64'd0, "R8 set outside");
    ask(7, "R8 set outside ignored");

    // R3: dynamic bits
    cmd(3'd1, 0, 64'd2, "R8 enter dyn");
    cmd(3'd1, 0, 64'd1, "R8 nested enter");
    cmd(3'd3, 3, 64'd0, "R3 dyn set");
    cmd(3'd7, 3, 64'd0, "R12 dyn read");
    cmd(3'd2, 0, 64'd0, "R8 exit");
    ask(3, "R3 dyn protects");
    ask(4, "R3 neighbour open");

    // R4: persistent program, then dyn cleared still blocked
    cmd(3'd1, 0, 64'd1, "R8 enter per");
    cmd(3'd3, 5, 64'd0, "R4 per program");
    cmd(3'd7, 5, 64'd0, "R12 per read");
    cmd(3'd2, 0, 64'd0, "R8 exit");
    cmd(3'd1, 0, 64'd2, "R8 enter dyn");
    cmd(3'd4, 5, 64'd0, "R3 dyn clear");
    cmd(3'd2, 0, 64'd0, "R8 exit");
    ask(5, "R3 per overrides dyn");

    // R6 / R4 / R5: freeze then try to change
    cmd(3'd1, 0, 64'd1, "R8 enter per");
    cmd(3'd5, 0, 64'd0, "R6 freeze");
    cmd(3'd3, 6, 64'd0, "R4 program while locked");
    cmd(3'd4, 9, 64'd0, "R5 erase while locked");
    cmd(3'd7, 6, 64'd0, "R4 locked read 6");
    cmd(3'd7, 5, 64'd0, "R5 locked read 5");
    cmd(3'd2, 0, 64'd0, "R8 exit");
    ask(6, "R4 locked no program");
    ask(5, "R5 locked no erase");

    // R7: hardware reset
    hw_reset();
    ask(3, "R7 dyn cleared");
    ask(5, "R7 per kept");
    cmd(3'd1, 0, 64'd0, "R8 enter mode");
    cmd(3'd7, 0, 64'd0, "R7 lock reopened");
    cmd(3'd2, 0, 64'd0, "R8 exit");

    // R5: erase all, arbitrary sector
    cmd(3'd1, 0, 64'd1, "R8 enter per");
    cmd(3'd3, 11, 64'd0, "R4 program 11");
    cmd(3'd4, 2, 64'd0, "R5 erase all");
    cmd(3'd2, 0, 64'd0, "R8 exit");
    ask(5, "R5 erased 5");
    ask(11, "R5 erased 11");

    // R10: password program and read
    cmd(3'd1, 0, 64'd3, "R8 enter pw");
    cmd(3'd3, 0, 64'hA5A5_1234_0F0F_C3C3, "R10 pw program");
    cmd(3'd7, 0, 64'd0, "R10 pw read");
    cmd(3'd2, 0, 64'd0, "R8 exit");

    // R9: mode register one-time and exclusive
    cmd(3'd1, 0, 64'd0, "R8 enter mode");
    cmd(3'd3, 0, 64'd3, "R9 both bits rejected");
    cmd(3'd7, 0, 64'd0, "R9 still zero");
    cmd(3'd3, 0, 64'd2, "R9 password mode");
    cmd(3'd3, 0, 64'd1, "R9 second program ignored");
    cmd(3'd7, 0, 64'd0, "R9 mode sticky");
    cmd(3'd2, 0, 64'd0, "R8 exit");

    // R10: password hidden and frozen
    cmd(3'd1, 0, 64'd3, "R8 enter pw");
    cmd(3'd3, 0, 64'd0, "R10 pw program ignored");
    cmd(3'd7, 0, 64'd0, "R10 pw hidden");
    cmd(3'd2, 0, 64'd0, "R8 exit");

    // R7 in password mode: lock comes up closed
    hw_reset();
    cmd(3'd1, 0, 64'd0, "R8 enter mode");
    cmd(3'd7, 0, 64'd0, "R7 lock closed in pw mode");
    cmd(3'd2, 0, 64'd0, "R8 exit");

    // R11: unlock
    cmd(3'd1, 0, 64'd3, "R8 enter pw");
    cmd(3'd6, 0, 64'h1, "R11 wrong password");
    cmd(3'd2, 0, 64'd0, "R8 exit");
    cmd(3'd1, 0, 64'd0, "R8 enter mode");
    cmd(3'd7, 0, 64'd0, "R11 still locked");
    cmd(3'd2, 0, 64'd0, "R8 exit");
    cmd(3'd1, 0, 64'd3, "R8 enter pw");
    cmd(3'd6, 0, 64'hA5A5_1234_0F0F_C3C3, "R11 right password");
    cmd(3'd2, 0, 64'd0, "R8 exit");
    cmd(3'd1, 0, 64'd0, "R8 enter mode");
    cmd(3'd7, 0, 64'd0, "R11 unlocked");
    cmd(3'd2, 0, 64'd0, "R8 exit");

    // random phase, starting again from power-on
    @(negedge clk); por = 1'b1;
    @(negedge clk); por = 1'b0;
    model_power_on();
    for (int i = 0; i < 3000; i++) begin
      int r, s;
      logic [PW_W-1:0] d;
      r = int'($urandom % 100);
      s = int'($urandom % NS);
      d = {$urandom, $urandom};
      if (r < 10)      cmd(3'd1, s, d, "R8 rnd enter");
      else if (r < 18) cmd(3'd2, s, d, "R8 rnd exit");
      else if (r < 34) cmd(3'd3, s, (m_ctx == 1) ? 64'(d[1:0]) : d, "R4 rnd set");
      else if (r < 44) cmd(3'd4, s, d, "R5 rnd clear");
      else if (r < 48) cmd(3'd5, s, d, "R6 rnd lock");
      else if (r < 54) cmd(3'd6, s, (d[0] ? m_pw : d), "R11 rnd unlock");
      else if (r < 70) cmd(3'd7, s, d, "R12 rnd read");
      else if (r < 98) ask(s, "R2 rnd allow");
      else             hw_reset();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule